// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This block performs the one-time configuration of a serially programmed frequency synthesizer once supply is applied. On a start pulse it captures three 24-bit register words and sends them over a three-wire port (serial clock, serial data, latch strobe). The words go out in a fixed order: reference divider word, then control word, then feedback divider word. The data for each word is shifted most significant bit first, and each word is committed by a strobe after its last bit.

The reference and control words follow each other with no enforced pause. After the control word has been committed, the sequencer waits out a settling interval before it sends the feedback divider word. The interval gives the oscillator bias time to settle, so that band selection can land on the right band. The interval is either long (default 5 ms) or reduced (default 600 µs). Both lengths are converted into system-clock counts from a clock-frequency parameter. An input chooses between them, and it is sampled at start.

The serial port has no back-pressure. The three words are control-level inputs that are captured only when a start pulse is accepted. The `busy` and `done` pins are plain status levels and pulses.

Top module: `synth_pwrup_seq`

## Requirements
- R1: After an accepted start, exactly three words are committed, in this order: the `word_ref` value, then the `word_ctl` value, then the `word_fb` value, each as captured at start.
- R2: Each word is exactly 24 bits, sent most significant bit first. `ser_data` changes only while `ser_clk` is low, so the receiver samples it on the rising edge of `ser_clk`.
- R3: `ser_clk` has a period of 2*HALF_DIV system clocks while a word is shifting, and it stays low at all other times.
- R4: `ser_le` is low while bits shift. It rises on the same edge as the final falling edge of `ser_clk`, stays high for LE_CYCLES system clocks, and is low again before the next word's first bit.
- R5: Between the strobe of the reference word and the strobe of the control word there is no added wait. The control word's strobe rises within 2*HALF_DIV*24 + 4 cycles of the previous strobe falling.
- R6: With `sel_short` = 0 at start, at least the long interval (LONG_US of system clock) passes between the fall of the control word's strobe and the first clock edge of the feedback word. Measured to that word's strobe rise, the gap lies between interval + 2*HALF_DIV*24 and that value + 6 cycles.
- R7: With `sel_short` = 1 at start, the same gap relation holds with the reduced interval (SHORT_US).
- R8: A start pulse while `busy` is high is ignored. It changes neither the words sent nor the number of strobes.
- R9: `done` is high for exactly one cycle after the feedback word is committed, and `busy` is low in that same cycle. A start in that cycle is accepted.
- R10: While synchronous reset `rst` is high, and in the cycle after it, `ser_clk`, `ser_data`, `ser_le`, `busy` and `done` are all low.
- R11: `busy` is high in the cycle after an accepted start and stays high until the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the sequence |
| sel_short | input | 1 | 1 selects the reduced settling interval (sampled at start) |
| word_ref | input | 24 | Reference divider word, sent first |
| word_ctl | input | 24 | Control word, sent second |
| word_fb | input | 24 | Feedback divider word, sent last |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can land in the same cycle: the completion pulse that ends one run, and the acceptance of a start request that begins the next. The bench provokes this by raising `start` at the very sampling point where it first sees `done` high, so the request is captured on the edge that closes the `done` cycle. The result is judged by the scoreboard: a second complete three-word stream must appear in the right order with the right contents and timing, and `busy` must rise one cycle after the request.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND_R, ST_SEND_C, ST_SETTLE, ST_SEND_N
  } seq_st_e;

  typedef enum logic [1:0] {
    SH_IDLE, SH_SHIFT, SH_LATCH
  } sh_st_e;

  localparam longint US_PER_S = 1_000_000;

  function automatic longint us_to_cycles(input longint clk_hz, input longint us);
    longint c;
    c = (clk_hz * us + US_PER_S - 1) / US_PER_S;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/sclk_div.sv
module sclk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  generate
    if (HALF_DIV <= 1) begin : g_nodiv
      assign tick = en;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          cnt <= '0;
        end else if (cnt == CW'(HALF_DIV - 1)) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign tick = en && (cnt == CW'(HALF_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/word_shifter.sv
module word_shifter
  import pwrup_pkg::*;
#(
  parameter int W         = 24,
  parameter int LE_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         tick,
  output logic         sclk,
  output logic         sdata,
  output logic         le,
  output logic         shifting,
  output logic         done
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int LW = $clog2(LE_CYCLES + 1);

  sh_st_e        st;
  logic [W-1:0]  sreg;
  logic [BW-1:0] bitn;
  logic [LW-1:0] lec;

  assign shifting = (st == SH_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SH_IDLE;
      sreg  <= '0;
      bitn  <= '0;
      lec   <= '0;
      sclk  <= 1'b0;
      sdata <= 1'b0;
      le    <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (load) begin
            sreg  <= word;
            sdata <= word[W-1];
            bitn  <= '0;
            sclk  <= 1'b0;
            st    <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitn == BW'(W - 1)) begin
                sdata <= 1'b0;
                le    <= 1'b1;
                lec   <= '0;
                st    <= SH_LATCH;
              end else begin
                bitn  <= bitn + 1'b1;
                sreg  <= sreg << 1;
                sdata <= sreg[W-2];
              end
            end
          end
        end
        SH_LATCH: begin
          if (lec == LW'(LE_CYCLES - 1)) begin
            le   <= 1'b0;
            done <= 1'b1;
            st   <= SH_IDLE;
          end else begin
            lec <= lec + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  AST_LE_QUIET_SHIFT: assert property (@(posedge clk) disable iff (rst) shifting |-> !le); // R4
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst) !shifting |-> !sclk); // R3
  AST_DATA_HELD_RISE: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> $stable(sdata)); // R2
  AST_LE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst) $rose(le) |-> $fell(sclk)); // R4
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        if (cnt == limit - 1'b1) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) run |-> (cnt < limit)); // R6
endmodule

// File: rtl/synth_pwrup_seq.sv
module synth_pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int     W         = 24,
  parameter longint CLK_HZ    = 200_000_000,
  parameter longint LONG_US   = 5000,
  parameter longint SHORT_US  = 600,
  parameter int     HALF_DIV  = 2,
  parameter int     LE_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sel_short,
  input  logic [W-1:0] word_ref,
  input  logic [W-1:0] word_ctl,
  input  logic [W-1:0] word_fb,
  output logic         ser_clk,
  output logic         ser_data,
  output logic         ser_le,
  output logic         busy,
  output logic         done
);
  localparam longint LONG_CYC  = us_to_cycles(CLK_HZ, LONG_US);
  localparam longint SHORT_CYC = us_to_cycles(CLK_HZ, SHORT_US);
  localparam longint MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int     CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);

  seq_st_e      st;
  logic [W-1:0] cur_word, hold_c, hold_n;
  logic         use_short, ld;
  logic         tick, shifting, sh_done, tmr_start, tmr_exp;

  assign tmr_start = (st == ST_SEND_C) && sh_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur_word  <= '0;
      hold_c    <= '0;
      hold_n    <= '0;
      use_short <= 1'b0;
      ld        <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      ld   <= 1'b0;
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            cur_word  <= word_ref;
            hold_c    <= word_ctl;
            hold_n    <= word_fb;
            use_short <= sel_short;
            ld        <= 1'b1;
            busy      <= 1'b1;
            st        <= ST_SEND_R;
          end
        end
        ST_SEND_R: begin
          if (sh_done) begin
            cur_word <= hold_c;
            ld       <= 1'b1;
            st       <= ST_SEND_C;
          end
        end
        ST_SEND_C: begin
          if (sh_done) st <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (tmr_exp) begin
            cur_word <= hold_n;
            ld       <= 1'b1;
            st       <= ST_SEND_N;
          end
        end
        ST_SEND_N: begin
          if (sh_done) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .en(shifting), .tick(tick)
  );

  word_shifter #(.W(W), .LE_CYCLES(LE_CYCLES)) u_shift (
    .clk(clk), .rst(rst), .load(ld), .word(cur_word), .tick(tick),
    .sclk(ser_clk), .sdata(ser_data), .le(ser_le),
    .shifting(shifting), .done(sh_done)
  );

  settle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start),
    .limit(use_short ? SHORT_LIM : LONG_LIM), .expired(tmr_exp)
  );

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R11
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (rst) (st == ST_SETTLE) |-> (!ser_le && !ser_clk)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && start && st == ST_SETTLE) |=> $stable(hold_n)); // R8
endmodule

// File: tb/synth_pwrup_seq_test.sv
`timescale 1ns/1ps
module synth_pwrup_seq_test;
  localparam int     W        = 24;
  localparam int     HALF     = 2;
  localparam int     LEC      = 2;
  localparam longint CLK_HZ   = 1_000_000;
  localparam longint LONG_US  = 2000;
  localparam longint SHORT_US = 300;
  localparam longint LONG_CYC  = 2000;
  localparam longint SHORT_CYC = 300;
  localparam longint WORD_CYC  = 2 * HALF * W;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, sel_short = 1'b0;
  logic [W-1:0] w_r = '0, w_c = '0, w_n = '0;
  logic ser_clk, ser_data, ser_le, busy, done;

  synth_pwrup_seq #(.W(W), .CLK_HZ(CLK_HZ), .LONG_US(LONG_US), .SHORT_US(SHORT_US),
                    .HALF_DIV(HALF), .LE_CYCLES(LEC)) uut (
    .clk(clk), .rst(rst), .start(start), .sel_short(sel_short),
    .word_ref(w_r), .word_ctl(w_c), .word_fb(w_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  longint cyc = 0;
  bit finished = 0;
  logic [W-1:0] exp_q[$];
  longint gap_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: decodes the serial stream and pops expected words
  logic prev_sclk = 0, prev_sdata = 0, prev_le = 0, prev_done = 0;
  logic [W-1:0] sh = '0;
  int nbits = 0, le_count = 0;
  longint last_fall = -1, last_rise = 0, le_rise = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_clk && !prev_sclk) begin
        chk(ser_data == prev_sdata, "R2", "data moved at clock rise", ser_data, prev_sdata);
        chk(!ser_le, "R4", "strobe high while shifting", ser_le, 0);
        sh = {sh[W-2:0], ser_data};
        nbits++;
        if (nbits > 1) chk(cyc - last_rise == 2 * HALF, "R3", "serial clock period", cyc - last_rise, 2 * HALF);
        last_rise = cyc;
      end
      if (ser_clk && !busy) chk(0, "R3", "serial clock high while idle", 1, 0);
      if (ser_le && !prev_le) begin
        le_count++;
        chk(nbits == W, "R2", "bits per word", nbits, W);
        chk(!ser_clk, "R4", "serial clock low at strobe", ser_clk, 0);
        if (exp_q.size() > 0) begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(sh == e, "R1", "committed word", sh, e);
        end else begin
          chk(0, "R8", "unexpected strobe", sh, 0);
        end
        if (last_fall >= 0) gap_q.push_back(cyc - last_fall);
        nbits = 0;
        le_rise = cyc;
      end
      if (!ser_le && prev_le) begin
        chk(cyc - le_rise == LEC, "R4", "strobe width", cyc - le_rise, LEC);
        last_fall = cyc;
      end
      if (done && prev_done) chk(0, "R9", "done longer than one cycle", 2, 1);
    end
    prev_sclk  = ser_clk;
    prev_sdata = ser_data;
    prev_le    = ser_le;
    prev_done  = done;
  end

  // Driver: pushes expected words, pulses start
  task automatic begin_seq(input logic [W-1:0] r, input logic [W-1:0] c,
                           input logic [W-1:0] n, input bit s);
    exp_q.push_back(r);
    exp_q.push_back(c);
    exp_q.push_back(n);
    gap_q.delete();
    last_fall = -1;
    w_r = r; w_c = c; w_n = n; sel_short = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R11", "busy after start", busy, 1);
  endtask

  task automatic wait_done();
    do begin
      @(negedge clk);
      if (!done) chk(busy || done, "R11", "busy held during run", busy, 1);
    end while (!done);
    chk(!busy, "R9", "busy low in done cycle", busy, 0);
  endtask

  task automatic check_gaps(input bit s);
    longint lim;
    lim = s ? SHORT_CYC : LONG_CYC;
    chk(gap_q.size() == 2, "R1", "strobe gaps seen", gap_q.size(), 2);
    if (gap_q.size() == 2) begin
      chk(gap_q[0] >= WORD_CYC && gap_q[0] <= WORD_CYC + 4, "R5",
          "ref-to-control gap", gap_q[0], WORD_CYC + 2);
      chk(gap_q[1] >= lim + WORD_CYC && gap_q[1] <= lim + WORD_CYC + 6,
          s ? "R7" : "R6", "control-to-feedback gap", gap_q[1], lim + WORD_CYC + 3);
    end
    chk(exp_q.size() == 0, "R1", "all words committed", exp_q.size(), 0);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(!ser_clk && !ser_data && !ser_le && !busy && !done, "R10", "outputs in reset",
        {ser_clk, ser_data, ser_le, busy, done}, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(!ser_clk && !ser_data && !ser_le && !busy && !done, "R10", "outputs after reset",
        {ser_clk, ser_data, ser_le, busy, done}, 0);

    // long interval, mixed pattern
    begin_seq(24'hA5C3_0F, 24'h123456, 24'hFEDCBA, 1'b0);
    wait_done();
    check_gaps(1'b0);

    // short interval, edge patterns
    begin_seq(24'hFFFFFF, 24'h000001, 24'h800000, 1'b1);
    wait_done();
    check_gaps(1'b1);

    // start while busy is ignored
    base = le_count;
    begin_seq(24'h0F0F0F, 24'hF0F0F0, 24'h5A5A5A, 1'b0);
    repeat (400) @(negedge clk);
    w_r = 24'h111111; w_c = 24'h222222; w_n = 24'h333333; sel_short = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_gaps(1'b0);
    repeat (300) @(negedge clk);
    chk(le_count == base + 3, "R8", "strobe count after ignored start", le_count - base, 3);
    chk(!busy, "R8", "idle after ignored start", busy, 0);

    // start in the done cycle is accepted
    begin_seq(24'hC0FFEE, 24'hBADF00, 24'h0BEEF0, 1'b1);
    wait_done();
    check_gaps(1'b1);
    begin_seq(24'h13579B, 24'h2468AC, 24'hDEAD01, 1'b1);
    wait_done();
    check_gaps(1'b1);

    repeat (20) @(negedge clk);
    chk(!ser_clk && !ser_le && !busy, "R3", "idle lines at end", {ser_clk, ser_le, busy}, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      chk(0, "R1", "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule